// File: doc/BRIEF.md
# Bitwise Three-Input Table Logic Execution Unit

This execution unit serves a 64-bit register-file instruction that applies any three-input Boolean function to every bit position on its own. The three operands are the present value of the destination register and the values of two source registers. An 8-entry truth table carried in the instruction word selects the function. Because the destination register is both an operand and the target, the operation is a read-modify-write of that register.

The unit decodes the 32-bit instruction word. It drives the three register indices that the register file must read combinationally. It accepts a valid strobe together with the three operand values. One clock later it presents the result, the destination index and a write enable. When the record flag of the instruction is set, it also presents a 4-bit condition field that summarises the result. Instructions whose opcode fields do not belong to this unit are flagged and produce no write.

Top module: `tlut_unit`

## Requirements
- R1: Instruction bits are numbered MSB-first, with bit 0 held in `instr[31]`. The destination index sits in bits 6-10 (`instr[25:21]`), the first source index in bits 11-15 (`instr[20:16]`) and the second source index in bits 16-20 (`instr[15:11]`). These three indices appear combinationally on `rd_t_idx`, `rd_a_idx` and `rd_b_idx`. The destination index appears on `wr_addr` one cycle after the instruction is accepted.
- R2: Result bit i equals table entry k, where k = {rt_val[i], ra_val[i], rb_val[i]}. Table entry k is instruction bit 21+k (MSB-first), which is `instr[10-k]`. Entry 0 applies when all three operand bits are 0, and entry 7 applies when all three are 1.
- R3: Every cycle in which `in_valid` is high is followed by exactly one cycle in which `out_valid` is high, with the result of that instruction. Instructions on back-to-back cycles produce back-to-back results.
- R4: `wr_en` is high in the output cycle only when the primary opcode (bits 0-5, `instr[31:26]`) equals `PRI_OPC` and the extended opcode (bits 29-30, `instr[2:1]`) equals `EXT_OPC`.
- R5: When either opcode field does not match, `not_mine` is high in the output cycle, and `wr_en` and `cr_valid` stay low.
- R6: The record flag is bit 31 (`instr[0]`). `cr_valid` is high in the output cycle exactly when the instruction matches and its record flag is 1. With the record flag at 0, `cr_valid` stays low.
- R7: The condition field is coded as `cr_field[3]` = result negative as a signed value, `[2]` = result positive (non-zero and not negative), `[1]` = result zero, and `[0]` = the `so_in` value sampled together with the instruction.
- R8: After reset, `out_valid`, `wr_en`, `cr_valid`, `not_mine`, `result`, `wr_addr` and `cr_field` are all zero.
- R9: In a cycle that follows one with `in_valid` low, `out_valid`, `wr_en`, `cr_valid` and `not_mine` are low, and `result` keeps its previous value.
- R10: The old destination value is the most significant bit of the table index. A table holding only entry 4 yields rt_val & ~ra_val & ~rb_val, and a table holding entries 4-7 yields rt_val unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rt_val | input | 64 | Current destination register value |
| ra_val | input | 64 | First source register value |
| rb_val | input | 64 | Second source register value |
| so_in | input | 1 | Summary-overflow bit to copy into the condition field |
| rd_t_idx | output | 5 | Destination register index to read (combinational) |
| rd_a_idx | output | 5 | First source register index (combinational) |
| rd_b_idx | output | 5 | Second source register index (combinational) |
| out_valid | output | 1 | Registered result cycle |
| result | output | 64 | Computed value |
| wr_en | output | 1 | Write result to destination register |
| wr_addr | output | 5 | Destination register index for the write |
| cr_valid | output | 1 | Condition field update is valid |
| cr_field | output | 4 | Condition field {neg, pos, zero, so} |
| not_mine | output | 1 | Accepted instruction does not belong to this unit |

## Verification
The assertions assume that the operand values and `so_in` are stable and meaningful whenever `in_valid` is high, and that the three operand buses already hold the registers named by the decoded indices. They make no assumption about the instruction encoding, so mismatched opcodes are legal stimulus. The bench drives every input only on falling edges and holds it through the rising edge. It uses operand patterns chosen so that each of the eight table indices occurs across the 64 bit positions.

// File: rtl/tlut_pkg.sv
// Package: shared instruction-field layout for the table logic unit.
// Assumes a 32-bit instruction word numbered MSB-first (bit 0 = instr[31]).
package tlut_pkg;
    localparam int ILEN    = 32;
    localparam int IDX_W   = 5;
    localparam int TBL_N   = 8;
    localparam int PRI_W   = 6;
    localparam int EXT_W   = 2;
    // LSB-numbered position of table entry 0 (MSB-first bit 21)
    localparam int TBL_E0  = ILEN - 1 - 21;

    typedef struct packed {
        logic [PRI_W-1:0] pri;
        logic [IDX_W-1:0] t_idx;
        logic [IDX_W-1:0] a_idx;
        logic [IDX_W-1:0] b_idx;
        logic [TBL_N-1:0] tbl;   // tbl[k] = entry for index k
        logic [EXT_W-1:0] ext;
        logic             rec;
    } tlut_fields_t;
endpackage

// File: rtl/tlut_decode.sv
// Module: splits the instruction word into fields and checks ownership.
// Assumes the field layout fixed in tlut_pkg; table entries are reordered
// so that tbl[k] is the entry selected by index value k.
module tlut_decode
    import tlut_pkg::*;
#(
    parameter logic [PRI_W-1:0] PRI_OPC = 6'd5,
    parameter logic [EXT_W-1:0] EXT_OPC = 2'd1
) (
    input  logic [ILEN-1:0] instr,
    output tlut_fields_t    fields,
    output logic            match
);
    // Reorder table entries: entry k lives at LSB-numbered bit TBL_E0-k
    for (genvar k = 0; k < TBL_N; k++) begin : g_tbl
        assign fields.tbl[k] = instr[TBL_E0-k];
    end

    // Pull the fixed-position fields
    always_comb begin
        fields.pri   = instr[31:26];
        fields.t_idx = instr[25:21];
        fields.a_idx = instr[20:16];
        fields.b_idx = instr[15:11];
        fields.ext   = instr[2:1];
        fields.rec   = instr[0];
    end

    // Ownership: both opcode fields must match this unit
    always_comb match = (fields.pri == PRI_OPC) && (fields.ext == EXT_OPC);
endmodule

// File: rtl/tlut_eval.sv
// Module: per-bit three-input table lookup across the data width.
// Assumes index order {t, a, b} with t as the most significant bit.
module tlut_eval
    import tlut_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  t_val,
    input  logic [XLEN-1:0]  a_val,
    input  logic [XLEN-1:0]  b_val,
    input  logic [TBL_N-1:0] tbl,
    output logic [XLEN-1:0]  res
);
    // One 8:1 selector per bit position
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        logic [2:0] sel;
        assign sel    = {t_val[i], a_val[i], b_val[i]};
        assign res[i] = tbl[sel];
    end
endmodule

// File: rtl/tlut_crgen.sv
// Module: builds the 4-bit condition field {neg, pos, zero, so}.
// Assumes the value is interpreted as two's-complement signed.
module tlut_crgen #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val,
    input  logic            so,
    output logic [3:0]      cr
);
    logic neg, zer;

    // Sign and zero detection, then priority-free encoding
    always_comb begin
        neg = val[XLEN-1];
        zer = ~|val;
        cr  = {neg, ~neg & ~zer, zer, so};
    end
endmodule

// File: rtl/tlut_unit.sv
// Module: top of the three-input table logic execution unit.
// Decodes the instruction, evaluates the per-bit function, registers the
// result once. Assumes operand buses carry the registers named by rd_*_idx
// in the same cycle that in_valid is high.
module tlut_unit
    import tlut_pkg::*;
#(
    parameter int               XLEN    = 64,
    parameter logic [PRI_W-1:0] PRI_OPC = 6'd5,
    parameter logic [EXT_W-1:0] EXT_OPC = 2'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ILEN-1:0]  instr,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [XLEN-1:0]  ra_val,
    input  logic [XLEN-1:0]  rb_val,
    input  logic             so_in,
    output logic [IDX_W-1:0] rd_t_idx,
    output logic [IDX_W-1:0] rd_a_idx,
    output logic [IDX_W-1:0] rd_b_idx,
    output logic             out_valid,
    output logic [XLEN-1:0]  result,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic             cr_valid,
    output logic [3:0]       cr_field,
    output logic             not_mine
);
    tlut_fields_t    f;
    logic            own;
    logic [XLEN-1:0] res_c;
    logic [3:0]      cr_c;

    tlut_decode #(.PRI_OPC(PRI_OPC), .EXT_OPC(EXT_OPC)) u_dec (
        .instr  (instr),
        .fields (f),
        .match  (own)
    );

    tlut_eval #(.XLEN(XLEN)) u_eval (
        .t_val (rt_val),
        .a_val (ra_val),
        .b_val (rb_val),
        .tbl   (f.tbl),
        .res   (res_c)
    );

    tlut_crgen #(.XLEN(XLEN)) u_cr (
        .val (res_c),
        .so  (so_in),
        .cr  (cr_c)
    );

    // Register-file read indices straight from the decoder
    always_comb begin
        rd_t_idx = f.t_idx;
        rd_a_idx = f.a_idx;
        rd_b_idx = f.b_idx;
    end

    // Single output stage: strobes every cycle, data only on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            cr_valid  <= 1'b0;
            not_mine  <= 1'b0;
            result    <= '0;
            wr_addr   <= '0;
            cr_field  <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid & own;
            cr_valid  <= in_valid & own & f.rec;
            not_mine  <= in_valid & ~own;
            if (in_valid) begin
                result   <= res_c;
                wr_addr  <= f.t_idx;
                cr_field <= cr_c;
            end
        end
    end
endmodule

// File: rtl/tlut_unit_chk.sv
// Checker: temporal properties of tlut_unit, bound to every instance.
// Assumes inputs are sampled at the rising edge like the design does.
module tlut_unit_chk #(
    parameter int         XLEN    = 64,
    parameter logic [5:0] PRI_OPC = 6'd5,
    parameter logic [1:0] EXT_OPC = 2'd1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] rt_val,
    input logic [XLEN-1:0] ra_val,
    input logic [XLEN-1:0] rb_val,
    input logic            so_in,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            wr_en,
    input logic [4:0]      wr_addr,
    input logic            cr_valid,
    input logic [3:0]      cr_field,
    input logic            not_mine
);
    logic [2:0] j_lo, j_hi;
    logic       exp_lo, exp_hi, owned;

    // Expected result bits at both ends of the word
    always_comb begin
        j_lo   = {rt_val[0], ra_val[0], rb_val[0]};
        j_hi   = {rt_val[XLEN-1], ra_val[XLEN-1], rb_val[XLEN-1]};
        exp_lo = instr[4'd10 - {1'b0, j_lo}];
        exp_hi = instr[4'd10 - {1'b0, j_hi}];
        owned  = (instr[31:26] == PRI_OPC) && (instr[2:1] == EXT_OPC);
    end

    assert_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_addr == $past(instr[25:21]));
    assert_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result[0] == $past(exp_lo));
    assert_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result[XLEN-1] == $past(exp_hi));
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_en == $past(owned));
    assert_foreign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(not_mine && (wr_en || cr_valid)));
    assert_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> cr_valid == $past(owned && instr[0]));
    assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> $countones(cr_field[3:1]) == 1);
    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> cr_field[1] == (result == '0));
    assert_so_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> cr_field[0] == $past(so_in));
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !wr_en && !cr_valid && !not_mine);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
endmodule

bind tlut_unit tlut_unit_chk #(.XLEN(XLEN), .PRI_OPC(PRI_OPC), .EXT_OPC(EXT_OPC)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rt_val(rt_val), .ra_val(ra_val), .rb_val(rb_val), .so_in(so_in),
    .out_valid(out_valid), .result(result), .wr_en(wr_en), .wr_addr(wr_addr),
    .cr_valid(cr_valid), .cr_field(cr_field), .not_mine(not_mine)
);

// File: tb/tlut_unit_tb.sv
module tlut_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] PRI = 6'd5;
    localparam logic [1:0] EXT = 2'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rt_val = '0, ra_val = '0, rb_val = '0;
    logic        so_in = 1'b0;
    logic [4:0]  rd_t_idx, rd_a_idx, rd_b_idx, wr_addr;
    logic        out_valid, wr_en, cr_valid, not_mine;
    logic [63:0] result;
    logic [3:0]  cr_field;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlut_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rt_val(rt_val), .ra_val(ra_val), .rb_val(rb_val), .so_in(so_in),
        .rd_t_idx(rd_t_idx), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .out_valid(out_valid), .result(result), .wr_en(wr_en), .wr_addr(wr_addr),
        .cr_valid(cr_valid), .cr_field(cr_field), .not_mine(not_mine)
    );

    // Operand patterns covering all eight indices across bit positions
    localparam logic [63:0] PT = 64'hF0F0_F0F0_0F0F_0F0F;
    localparam logic [63:0] PA = 64'hCCCC_3333_CCCC_3333;
    localparam logic [63:0] PB = 64'hAAAA_AAAA_5555_5555;

    function automatic logic [31:0] mk(input logic [5:0] pri, input logic [4:0] t,
                                       input logic [4:0] a, input logic [4:0] b,
                                       input logic [7:0] tbl, input logic [1:0] ext,
                                       input logic rec);
        logic [31:0] w;
        w = '0;
        w[31:26] = pri; w[25:21] = t; w[20:16] = a; w[15:11] = b;
        for (int k = 0; k < 8; k++) w[10-k] = tbl[k];
        w[2:1] = ext; w[0] = rec;
        return w;
    endfunction

    function automatic logic [63:0] model(input logic [7:0] tbl, input logic [63:0] t,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = tbl[{t[i], a[i], b[i]}];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one instruction, sample its output at the following falling edge
    task automatic issue(input logic [31:0] w, input logic [63:0] t, input logic [63:0] a,
                         input logic [63:0] b, input logic so);
        @(negedge clk);
        instr = w; rt_val = t; ra_val = a; rb_val = b; so_in = so; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 out_valid", {63'b0, out_valid}, 64'd0);
        chk("R8 strobes", {60'b0, wr_en, cr_valid, not_mine, 1'b0}, 64'd0);
        chk("R8 result", result, 64'd0);
        chk("R8 wr_addr/cr", {55'b0, wr_addr, cr_field}, 64'd0);
    endtask

    task automatic t_decode();
        @(negedge clk);
        instr = mk(PRI, 5'd19, 5'd7, 5'd28, 8'h00, EXT, 1'b0);
        #1;
        chk("R1 rd_t_idx", {59'b0, rd_t_idx}, 64'd19);
        chk("R1 rd_a_idx", {59'b0, rd_a_idx}, 64'd7);
        chk("R1 rd_b_idx", {59'b0, rd_b_idx}, 64'd28);
        issue(instr, PT, PA, PB, 1'b0);
        chk("R1 wr_addr", {59'b0, wr_addr}, 64'd19);
    endtask

    task automatic t_tables();
        logic [7:0] tbls [6] = '{8'h00, 8'hFF, 8'h96, 8'hE8, 8'hCC, 8'hAA};
        foreach (tbls[n]) begin
            issue(mk(PRI, 5'd3, 5'd4, 5'd5, tbls[n], EXT, 1'b0), PT, PA, PB, 1'b0);
            chk("R2 result", result, model(tbls[n], PT, PA, PB));
            chk("R3 out_valid", {63'b0, out_valid}, 64'd1);
            chk("R4 wr_en", {63'b0, wr_en}, 64'd1);
        end
        issue(mk(PRI, 5'd3, 5'd4, 5'd5, 8'h1B, EXT, 1'b0), 64'h0123_4567_89AB_CDEF,
              64'hFEDC_BA98_7654_3210, 64'h0F1E_2D3C_4B5A_6978, 1'b0);
        chk("R2 mixed", result, model(8'h1B, 64'h0123_4567_89AB_CDEF,
              64'hFEDC_BA98_7654_3210, 64'h0F1E_2D3C_4B5A_6978));
    endtask

    task automatic t_rmw();
        issue(mk(PRI, 5'd1, 5'd2, 5'd3, 8'h10, EXT, 1'b0), PT, PA, PB, 1'b0);
        chk("R10 entry4", result, PT & ~PA & ~PB);
        issue(mk(PRI, 5'd1, 5'd2, 5'd3, 8'hF0, EXT, 1'b0), 64'hDEAD_BEEF_0BAD_F00D, PA, PB, 1'b0);
        chk("R10 keep rt", result, 64'hDEAD_BEEF_0BAD_F00D);
    endtask

    task automatic t_record();
        issue(mk(PRI, 5'd1, 5'd2, 5'd3, 8'hF0, EXT, 1'b1), 64'hFFFF_FFFF_FFFF_FFFB, PA, PB, 1'b1);
        chk("R6 cr_valid", {63'b0, cr_valid}, 64'd1);
        chk("R7 negative", {60'b0, cr_field}, 64'b1001);
        issue(mk(PRI, 5'd1, 5'd2, 5'd3, 8'hF0, EXT, 1'b1), 64'd7, PA, PB, 1'b0);
        chk("R7 positive", {60'b0, cr_field}, 64'b0100);
        issue(mk(PRI, 5'd1, 5'd2, 5'd3, 8'hF0, EXT, 1'b1), 64'd0, PA, PB, 1'b1);
        chk("R7 zero", {60'b0, cr_field}, 64'b0011);
        issue(mk(PRI, 5'd1, 5'd2, 5'd3, 8'hF0, EXT, 1'b0), 64'd7, PA, PB, 1'b1);
        chk("R6 no record", {63'b0, cr_valid}, 64'd0);
    endtask

    task automatic t_foreign();
        issue(mk(6'd6, 5'd1, 5'd2, 5'd3, 8'hFF, EXT, 1'b1), PT, PA, PB, 1'b0);
        chk("R5 bad primary", {61'b0, not_mine, wr_en, cr_valid}, 64'b100);
        issue(mk(PRI, 5'd1, 5'd2, 5'd3, 8'hFF, 2'd2, 1'b1), PT, PA, PB, 1'b0);
        chk("R5 bad extended", {61'b0, not_mine, wr_en, cr_valid}, 64'b100);
        chk("R4 out_valid on foreign", {63'b0, out_valid}, 64'd1);
    endtask

    task automatic t_idle();
        logic [63:0] held;
        issue(mk(PRI, 5'd1, 5'd2, 5'd3, 8'h96, EXT, 1'b1), PT, PA, PB, 1'b0);
        held = result;
        instr = mk(PRI, 5'd1, 5'd2, 5'd3, 8'h00, EXT, 1'b1);
        rt_val = ~PT;
        @(negedge clk);
        chk("R9 strobes low", {60'b0, out_valid, wr_en, cr_valid, not_mine}, 64'd0);
        chk("R9 result held", result, held);
    endtask

    task automatic t_b2b();
        @(negedge clk);
        instr = mk(PRI, 5'd9, 5'd2, 5'd3, 8'hE8, EXT, 1'b0);
        rt_val = PT; ra_val = PA; rb_val = PB; in_valid = 1'b1;
        @(negedge clk);
        chk("R3 first", result, model(8'hE8, PT, PA, PB));
        chk("R1 first addr", {59'b0, wr_addr}, 64'd9);
        instr = mk(PRI, 5'd10, 5'd2, 5'd3, 8'h96, EXT, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R3 second", result, model(8'h96, PT, PA, PB));
        chk("R3 second valid", {63'b0, out_valid}, 64'd1);
        @(negedge clk);
        chk("R3 single pulse", {63'b0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_tables();
        t_rmw();
        t_record();
        t_foreign();
        t_idle();
        t_b2b();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule